// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the processor-facing bookkeeping for one CPU in an interrupt controller. When the CPU reads the acknowledge location, the block decides whether the current best pending source may preempt the interrupt that is running now. If it may, that source becomes the running interrupt. The block records which interrupt it displaced and issues a command to clear the source's pending bit. When the CPU writes an end-of-interrupt (EOI), the block retires the named interrupt and restores the running state that the retired interrupt had displaced.

Every interrupt ID has a link entry that holds the ID it preempted, so nested interrupts form a chain ending in the idle ID 1023. An EOI normally names the top of the chain. When it names an entry further down, a small walker follows the links one hop per clock and splices that entry out. While the walker runs, it holds off new requests. For level-sensitive sources that are enabled and whose input is still asserted, an EOI also asks for the pending bit to be set again.

Acknowledge and EOI requests are valid/ready inputs. A request is taken on a clock edge where valid and ready are both high. The requester holds valid, and the EOI data, until that edge. Both ready signals are low while a walk is in progress. When both requests are offered in the same cycle, the EOI is taken first and the acknowledge waits. Acknowledge responses, pending commands and the request-drop pulse are single-cycle outputs with no back-pressure, registered one clock after the accepting edge.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, and both request ready signals are high.
- R2: An accepted acknowledge returns ID 1023 and leaves the running ID and priority unchanged when the highest-pending ID is 1023 or out of range, or when its 8-bit priority, zero-extended, is not strictly below the running priority.
- R3: A successful acknowledge returns the highest-pending ID one cycle after acceptance. In that same cycle the running ID and priority take that ID and its priority, a clear-pending command names that ID, and the request-drop pulse is high.
- R4: An EOI naming the running ID makes the running ID equal to that ID's link, with the linked ID's priority. Returning to ID 1023 restores priority 0x100.
- R5: An EOI accepted while the running ID is 1023 changes nothing and issues no pending command.
- R6: An EOI of an in-range ID whose trigger bit is 0 (level), whose enable bit is 1 and whose level input is 1 issues a set-pending command for that ID one cycle after acceptance. An edge-mode, disabled or low source issues none.
- R7: An EOI naming an ID other than the running one leaves the running ID and priority unchanged. It rewrites the chain entry pointing to that ID so that it points to that ID's own link, so later EOIs skip the removed ID. An ID absent from the chain leaves every link as it was.
- R8: Only bits 9:0 of the EOI data select the interrupt ID; the upper bits are ignored.
- R9: An out-of-order EOI keeps both ready signals low for one cycle per link examined, from the running ID down to the match or to ID 1023.
- R10: When an acknowledge and an EOI are offered in the same cycle with the block idle, the acknowledge ready is low. The EOI is taken first, and the acknowledge is taken on a later edge using the post-EOI running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge request can be taken |
| ack_rsp_valid | output | 1 | Acknowledge result pulse |
| ack_rsp_id | output | 10 | Acknowledged ID, or 1023 |
| eoi_valid | input | 1 | EOI request valid |
| eoi_ready | output | 1 | EOI request can be taken |
| eoi_data | input | DATA_W | EOI write data; bits 9:0 are the ID |
| hp_id | input | 10 | Highest-pending ID from the selector |
| prio_flat | input | NUM_IRQ*PRIO_W | Per-ID priorities, ID n at bits n*PRIO_W upward |
| edge_mode | input | NUM_IRQ | Per-ID trigger bit, 1 = edge |
| src_en | input | NUM_IRQ | Per-ID enable bit |
| src_lvl | input | NUM_IRQ | Per-ID input level |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| pend_set_valid | output | 1 | Set-pending command pulse |
| pend_set_id | output | 10 | ID to set pending |
| pend_clr_valid | output | 1 | Clear-pending command pulse |
| pend_clr_id | output | 10 | ID to clear pending |
| irq_drop | output | 1 | Pulse to drop the CPU request line |

## Verification
An acknowledge and an EOI can fall in the same cycle. The bench raises both valids at one falling edge while interrupt 60 (priority 0x10) runs, with the EOI naming 60 and the highest-pending source at priority 0x20. Acknowledge ready must be low in that cycle and the running ID must return to 1023 first. The acknowledge must then return ID 61: had it been served first, priority 0x20 would not beat 0x10 and it would have returned 1023. Walk length is also measured in busy cycles for a mid-chain hit, a one-hop hit and an absent ID.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int ID_W = 10;
  typedef logic [ID_W-1:0] id_t;
  localparam id_t NO_IRQ = id_t'(1023);
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  id_t  waddr,
  input  id_t  wdata,
  input  id_t  ra_addr,
  output id_t  ra_data,
  input  id_t  rb_addr,
  output id_t  rb_data
);
  localparam int  IDX_W  = $clog2(NUM_IRQ);
  localparam id_t NUM_ID = id_t'(NUM_IRQ);

  id_t mem [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= NO_IRQ;
      else if (we && waddr == id_t'(g))      mem[g] <= wdata;
    end
  end

  // out-of-range IDs have no entry and read as the end of the chain
  assign ra_data = (ra_addr < NUM_ID) ? mem[ra_addr[IDX_W-1:0]] : NO_IRQ;
  assign rb_data = (rb_addr < NUM_ID) ? mem[rb_addr[IDX_W-1:0]] : NO_IRQ;

  // R7: only real entries are ever rewritten
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < NUM_ID);
endmodule

// File: rtl/irq_chain_walker.sv
module irq_chain_walker
  import irq_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  id_t  start_cur,
  input  id_t  start_tgt,
  output logic busy,
  output id_t  cur_idx,
  output id_t  tgt_idx,
  input  id_t  cur_link,
  input  id_t  tgt_link,
  output logic wr_en,
  output id_t  wr_addr,
  output id_t  wr_data
);
  logic busy_q;
  id_t  cur_q, tgt_q;
  logic hit, at_end;

  assign hit    = (cur_link == tgt_q) && (cur_link != NO_IRQ);
  assign at_end = (cur_link == NO_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= NO_IRQ;
      tgt_q  <= NO_IRQ;
    end else if (start) begin
      busy_q <= 1'b1;
      cur_q  <= start_cur;
      tgt_q  <= start_tgt;
    end else if (busy_q) begin
      if (hit || at_end) busy_q <= 1'b0;
      else               cur_q  <= cur_link;
    end
  end

  assign busy    = busy_q;
  assign cur_idx = cur_q;
  assign tgt_idx = tgt_q;
  assign wr_en   = busy_q && hit;
  assign wr_addr = cur_q;
  assign wr_data = tgt_link;

  // R9: a walk is never restarted while one is running
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R7: splicing an entry ends the walk
  a_r7_unlink_ends: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_valid,
  output logic                      ack_ready,
  output logic                      ack_rsp_valid,
  output logic [9:0]                ack_rsp_id,
  input  logic                      eoi_valid,
  output logic                      eoi_ready,
  input  logic [DATA_W-1:0]         eoi_data,
  input  logic [9:0]                hp_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [NUM_IRQ-1:0]        edge_mode,
  input  logic [NUM_IRQ-1:0]        src_en,
  input  logic [NUM_IRQ-1:0]        src_lvl,
  output logic [9:0]                run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      pend_set_valid,
  output logic [9:0]                pend_set_id,
  output logic                      pend_clr_valid,
  output logic [9:0]                pend_clr_id,
  output logic                      irq_drop
);
  localparam int  IDX_W = $clog2(NUM_IRQ);
  localparam int  RP_W  = PRIO_W + 1;
  localparam id_t NUM_ID = id_t'(NUM_IRQ);
  localparam logic [RP_W-1:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  function automatic logic [RP_W-1:0] prio_of(input id_t id,
                                              input logic [NUM_IRQ*PRIO_W-1:0] tbl);
    if (id < NUM_ID) return {1'b0, tbl[id[IDX_W-1:0]*PRIO_W +: PRIO_W]};
    return IDLE_PRIO;
  endfunction

  id_t run_q;
  logic [RP_W-1:0] rprio_q;

  logic walk_busy, walk_wr;
  id_t walk_cur, walk_tgt, walk_waddr, walk_wdata;
  id_t ra_addr, ra_data, rb_data;

  logic eoi_fire, ack_fire, run_active, walk_start, hp_ok;
  logic eoi_in, lvl_repend;
  id_t  eoi_id;
  logic [RP_W-1:0] hp_prio, pop_prio;

  assign eoi_ready  = !walk_busy;
  assign ack_ready  = !walk_busy && !eoi_valid;   // EOI wins a shared cycle
  assign eoi_fire   = eoi_valid && eoi_ready;
  assign ack_fire   = ack_valid && ack_ready;
  assign eoi_id     = eoi_data[ID_W-1:0];
  assign eoi_in     = eoi_id < NUM_ID;
  assign run_active = run_q != NO_IRQ;
  assign walk_start = eoi_fire && run_active && (eoi_id != run_q);

  assign lvl_repend = eoi_in && !edge_mode[eoi_id[IDX_W-1:0]] &&
                      src_en[eoi_id[IDX_W-1:0]] && src_lvl[eoi_id[IDX_W-1:0]];

  assign ra_addr  = walk_busy ? walk_cur : run_q;
  assign pop_prio = prio_of(ra_data, prio_flat);
  assign hp_prio  = prio_of(hp_id, prio_flat);
  assign hp_ok    = (hp_id != NO_IRQ) && (hp_id < NUM_ID) && (hp_prio < rprio_q);

  logic ack_wr;
  assign ack_wr = ack_fire && hp_ok;

  irq_link_table #(.NUM_IRQ(NUM_IRQ)) u_links (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ack_wr || walk_wr),
    .waddr   (ack_wr ? hp_id : walk_waddr),
    .wdata   (ack_wr ? run_q : walk_wdata),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (walk_tgt),
    .rb_data (rb_data)
  );

  irq_chain_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .start_cur (run_q),
    .start_tgt (eoi_id),
    .busy      (walk_busy),
    .cur_idx   (walk_cur),
    .tgt_idx   (walk_tgt),
    .cur_link  (ra_data),
    .tgt_link  (rb_data),
    .wr_en     (walk_wr),
    .wr_addr   (walk_waddr),
    .wr_data   (walk_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q          <= NO_IRQ;
      rprio_q        <= IDLE_PRIO;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= NO_IRQ;
      pend_set_valid <= 1'b0;
      pend_set_id    <= NO_IRQ;
      pend_clr_valid <= 1'b0;
      pend_clr_id    <= NO_IRQ;
      irq_drop       <= 1'b0;
    end else begin
      ack_rsp_valid  <= 1'b0;
      pend_set_valid <= 1'b0;
      pend_clr_valid <= 1'b0;
      irq_drop       <= 1'b0;
      if (eoi_fire && run_active) begin
        if (lvl_repend) begin
          pend_set_valid <= 1'b1;
          pend_set_id    <= eoi_id;
        end
        if (eoi_id == run_q) begin
          run_q   <= ra_data;
          rprio_q <= pop_prio;
        end
      end else if (ack_fire) begin
        ack_rsp_valid <= 1'b1;
        if (hp_ok) begin
          ack_rsp_id     <= hp_id;
          run_q          <= hp_id;
          rprio_q        <= hp_prio;
          pend_clr_valid <= 1'b1;
          pend_clr_id    <= hp_id;
          irq_drop       <= 1'b1;
        end else begin
          ack_rsp_id <= NO_IRQ;
        end
      end
    end
  end

  assign run_id   = run_q;
  assign run_prio = rprio_q;

  a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == NO_IRQ |-> run_prio == IDLE_PRIO);
  a_r2_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id == NO_IRQ) |-> $stable(run_id));
  a_r3_ack_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id != NO_IRQ) |-> (run_id == ack_rsp_id && irq_drop && pend_clr_valid));
  a_r5_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && run_id == NO_IRQ) |=> (run_id == NO_IRQ && !pend_set_valid));
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> (!eoi_ready && !ack_ready));
  a_r10_eoi_first: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !ack_ready);
endmodule

// File: tb/irq_ack_tracker_test.sv
module irq_ack_tracker_test;
  localparam int N = 96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ack_valid, ack_ready, ack_rsp_valid, eoi_valid, eoi_ready;
  logic [9:0] ack_rsp_id, hp_id, run_id, pend_set_id, pend_clr_id;
  logic [31:0] eoi_data;
  logic [7:0] prio [N];
  logic [N*8-1:0] prio_flat;
  logic [N-1:0] edge_mode, src_en, src_lvl;
  logic [8:0] run_prio;
  logic pend_set_valid, pend_clr_valid, irq_drop;

  always_comb for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = prio[i];

  irq_ack_tracker uut (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_id(ack_rsp_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_data(eoi_data),
    .hp_id(hp_id), .prio_flat(prio_flat), .edge_mode(edge_mode),
    .src_en(src_en), .src_lvl(src_lvl), .run_id(run_id), .run_prio(run_prio),
    .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id),
    .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id), .irq_drop(irq_drop)
  );

  int total = 0, bad = 0;
  int q_ack[$], q_set[$], q_clr[$];
  int e_ack, e_set, e_clr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_rsp_valid) begin
        if (q_ack.size() == 0) chk(0, "R3 unexpected ack response", ack_rsp_id, -1);
        else begin
          e_ack = q_ack.pop_front();
          chk(ack_rsp_id == 10'(e_ack), "R2/R3 ack response id", ack_rsp_id, e_ack);
        end
      end
      if (pend_set_valid) begin
        if (q_set.size() == 0) chk(0, "R6 unexpected set-pending", pend_set_id, -1);
        else begin
          e_set = q_set.pop_front();
          chk(pend_set_id == 10'(e_set), "R6 set-pending id", pend_set_id, e_set);
        end
      end
      if (pend_clr_valid) begin
        if (q_clr.size() == 0) chk(0, "R3 unexpected clear-pending", pend_clr_id, -1);
        else begin
          e_clr = q_clr.pop_front();
          chk(pend_clr_id == 10'(e_clr), "R3 clear-pending id", pend_clr_id, e_clr);
          chk(irq_drop == 1'b1, "R3 request drop with clear", irq_drop, 1);
        end
      end
    end
  end

  task automatic do_ack(input int hp, input int exp);
    @(negedge clk);
    hp_id = 10'(hp);
    q_ack.push_back(exp);
    if (exp != 1023) q_clr.push_back(exp);
    ack_valid = 1'b1;
    while (!ack_ready) @(negedge clk);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_eoi(input logic [31:0] d, input int set_exp);
    @(negedge clk);
    eoi_data = d;
    if (set_exp >= 0) q_set.push_back(set_exp);
    eoi_valid = 1'b1;
    while (!eoi_ready) @(negedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic check_run(input string req, input int id, input int pr);
    chk(run_id == 10'(id), {req, " running id"}, run_id, id);
    chk(run_prio == 9'(pr), {req, " running priority"}, run_prio, pr);
  endtask

  task automatic busy_len(input string req, input int exp);
    int n = 0;
    chk(ack_ready == 1'b0, {req, " ack held during walk"}, ack_ready, 0);
    while (!eoi_ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, {req, " walk busy cycles"}, n, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ack_valid = 1'b0; eoi_valid = 1'b0; eoi_data = '0; hp_id = 10'd1023;
    for (int i = 0; i < N; i++) prio[i] = 8'hFF;
    edge_mode = '1; src_en = '0; src_lvl = '0;
    edge_mode[5] = 1'b0; src_en[5] = 1'b1; src_lvl[5] = 1'b1;
    edge_mode[30] = 1'b0; src_en[30] = 1'b1; src_lvl[30] = 1'b1;
    src_en[20] = 1'b1; src_lvl[20] = 1'b1;             // edge: no re-pend
    edge_mode[10] = 1'b0; src_lvl[10] = 1'b1;          // disabled: no re-pend
    prio[10] = 8'h80; prio[20] = 8'h80; prio[30] = 8'h20;
    prio[40] = 8'h60; prio[41] = 8'h50; prio[42] = 8'h40; prio[43] = 8'h30;
    prio[60] = 8'h10; prio[61] = 8'h20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_run("R1", 1023, 256);
    chk(ack_ready == 1'b1, "R1 ack ready", ack_ready, 1);
    chk(eoi_ready == 1'b1, "R1 eoi ready", eoi_ready, 1);

    // R5 EOI while idle is ignored (source 5 would otherwise re-pend)
    do_eoi(32'd5, -1);
    @(negedge clk);
    check_run("R5", 1023, 256);

    // R2 nothing pending
    do_ack(1023, 1023);
    check_run("R2", 1023, 256);

    // R3 first acknowledge
    do_ack(10, 10);
    check_run("R3", 10, 128);

    // R2 equal priority refused, then R3 lower value accepted
    do_ack(20, 1023);
    check_run("R2 equal", 10, 128);
    prio[20] = 8'h40;
    do_ack(20, 20);
    do_ack(30, 30);
    check_run("R3 nested", 30, 32);

    // R7 out-of-order EOI of 20 (edge source: no re-pend), one hop
    do_eoi(32'd20, -1);
    busy_len("R9 one hop", 1);
    check_run("R7 middle removed", 30, 32);

    // R8 upper data bits ignored; R6 level re-pend for 30; R7 skip 20
    do_eoi(32'hABCD_F01E, 30);
    check_run("R8/R7 pop skips removed", 10, 128);

    // R4 pop to idle; source 10 disabled so no re-pend
    do_eoi(32'd10, -1);
    check_run("R4 pop to idle", 1023, 256);

    // R9 longer chain 43->42->41->40
    do_ack(40, 40);
    do_ack(41, 41);
    do_ack(42, 42);
    do_ack(43, 43);
    do_eoi(32'd40, -1);
    busy_len("R9 three hops", 3);
    check_run("R7 deep removal", 43, 48);
    do_eoi(32'd50, -1);
    busy_len("R9 absent id", 3);
    check_run("R7 absent id", 43, 48);
    do_eoi(32'hFFFF_FC2B, -1);
    check_run("R8/R4 pop 43", 42, 64);
    do_eoi(32'd42, -1);
    check_run("R4 pop 42", 41, 80);
    do_eoi(32'd41, -1);
    check_run("R7 tail relinked", 1023, 256);

    // R10 acknowledge and EOI offered together
    do_ack(60, 60);
    check_run("R10 setup", 60, 16);
    @(negedge clk);
    hp_id = 10'd61;
    q_ack.push_back(61);
    q_clr.push_back(61);
    eoi_data = 32'd60;
    eoi_valid = 1'b1;
    ack_valid = 1'b1;
    #1;
    chk(ack_ready == 1'b0, "R10 ack held behind eoi", ack_ready, 0);
    @(negedge clk);
    eoi_valid = 1'b0;
    check_run("R10 eoi first", 1023, 256);
    #1;
    chk(ack_ready == 1'b1, "R10 ack ready after eoi", ack_ready, 1);
    @(negedge clk);
    ack_valid = 1'b0;
    check_run("R10 ack after eoi", 61, 32);

    repeat (3) @(negedge clk);
    chk(q_ack.size() == 0, "R3 ack responses outstanding", q_ack.size(), 0);
    chk(q_set.size() == 0, "R6 set-pending outstanding", q_set.size(), 0);
    chk(q_clr.size() == 0, "R3 clear-pending outstanding", q_clr.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule